// File: doc/BRIEF.md
# Timer Input Capture Unit

This block takes a snapshot of a running timer when something happens on an external input line. Two 16-bit timers arrive as inputs, and a select bit chooses which one is sampled. A 4-bit mode word sets what counts as an event: every falling edge, every rising edge, every fourth rising edge or every sixteenth rising edge. It can also switch the unit off. The input goes through a synchronizer and an edge detector. In the divided modes a prescaler counter then decides which rising edge qualifies.

On each qualifying event the selected timer value is copied whole into the capture register, and the interrupt flag is set. The flag stays set until software pulses the clear input. A later event overwrites the capture register whether or not the old value was read. The prescaler counter is cleared only while the unit is off or in a non-capture mode. Moving directly between the two divided settings keeps the count, so the first capture after such a switch can come early. Writing the mode to off first and then to the new setting avoids this.

A small state machine sequences the unit. It has three states: `ST_OFF` (no capture mode), `ST_ARM` (waiting for an event) and `ST_GRAB` (loading the capture register and setting the flag). Its transitions are:
- enable: `ST_OFF` to `ST_ARM` when the mode becomes a capture mode.
- trigger: `ST_ARM` to `ST_GRAB` on a qualified event.
- resume: `ST_GRAB` to `ST_ARM` when there is no new event.
- retrigger: `ST_GRAB` to `ST_GRAB` on a new event.
- disable: any state to `ST_OFF` when the mode leaves capture.

Top module: `tcap_unit`

## Requirements
- R1: After reset the capture register reads 0, the flag is 0 and the prescaler counter is 0.
- R2: With mode 4'b0101, every rising edge of the input causes a capture, and falling edges cause none.
- R3: With mode 4'b0100, every falling edge of the input causes a capture, and rising edges cause none.
- R4: With mode 4'b0110 and the counter starting at zero, a capture happens on the 4th rising edge. The counter then returns to zero.
- R5: With mode 4'b0111 and the counter starting at zero, a capture happens on the 16th rising edge. The counter then returns to zero.
- R6: The capture loads the timer A input when the select input is 0 and the timer B input when it is 1.
- R7: Once set, the flag stays set until a cycle with the clear input high. When a capture and a clear fall in the same cycle, the flag ends up set.
- R8: A new capture overwrites the capture register even if the flag is still set. Between captures the register holds its value.
- R9: Mode 4'b0000, and every code outside 4'b0100 to 4'b0111, causes no capture and holds the prescaler counter at zero.
- R10: A direct switch between 4'b0111 and 4'b0110 keeps the prescaler count. If the kept count is at or above the new limit (ratio minus one), the next rising edge captures.
- R11: The flag and capture register update on the 4th rising clock edge after the input changes: two synchronizer stages, one cycle for the event, one for the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 4 | Mode word selecting the event kind or off |
| tsel_i | input | 1 | Timer select: 0 for timer A, 1 for timer B |
| pin_i | input | 1 | Asynchronous event input |
| tmr_a_i | input | TW | Timer A count |
| tmr_b_i | input | TW | Timer B count |
| flag_clr_i | input | 1 | Software clear of the flag |
| cap_o | output | TW | Capture register |
| flag_o | output | 1 | Sticky capture flag |

## Verification
The bench builds the unit with its defaults: TW = 16, two synchronizer stages and prescale ratios of 4 and 16. With these values the full sixteen-edge division can be reached in under a hundred cycles per step. The exact four-edge input-to-flag latency can be checked cycle by cycle. The early capture after a direct switch from divide-by-16 to divide-by-4 becomes visible: six counted edges exceed the new limit of three.

// File: rtl/tcap_pkg.sv
`timescale 1ns/1ps
package tcap_pkg;
    localparam logic [3:0] MODE_OFF    = 4'b0000;
    localparam logic [3:0] MODE_FALL   = 4'b0100;
    localparam logic [3:0] MODE_RISE   = 4'b0101;
    localparam logic [3:0] MODE_DIV_LO = 4'b0110;
    localparam logic [3:0] MODE_DIV_HI = 4'b0111;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_ARM  = 2'd1,
        ST_GRAB = 2'd2
    } cap_state_e;

    function automatic logic is_capture(input logic [3:0] m);
        return m[3:2] == 2'b01;
    endfunction

    function automatic logic is_scaled(input logic [3:0] m);
        return m[3:1] == 3'b011;
    endfunction
endpackage

// File: rtl/tcap_sync_edge.sv
`timescale 1ns/1ps
module tcap_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // synchronizer chain, one flop per stage
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) sync_q[0] <= 1'b0;
                else         sync_q[0] <= pin_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) sync_q[g] <= 1'b0;
                else         sync_q[g] <= sync_q[g-1];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) last_q <= 1'b0;
        else         last_q <= sync_q[STAGES-1];
    end

    assign rise_o = sync_q[STAGES-1] & ~last_q;
    assign fall_o = ~sync_q[STAGES-1] & last_q;
endmodule

// File: rtl/tcap_prescale.sv
`timescale 1ns/1ps
module tcap_prescale
    import tcap_pkg::*;
#(
    parameter int PS_LO = 4,
    parameter int PS_HI = 16,
    localparam int CW   = $clog2(PS_HI)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [3:0]    mode_i,
    input  logic          rise_i,
    input  logic          fall_i,
    output logic          evt_o,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW-1:0] LIM_LO = CW'(PS_LO - 1);
    localparam logic [CW-1:0] LIM_HI = CW'(PS_HI - 1);

    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] lim;
    logic          hit;

    always_comb begin
        lim = (mode_i == MODE_DIV_HI) ? LIM_HI : LIM_LO;
        // a count at or above the limit qualifies (early capture after switch)
        hit = rise_i && (cnt_q >= lim);
        unique case (mode_i)
            MODE_FALL:   evt_o = fall_i;
            MODE_RISE:   evt_o = rise_i;
            MODE_DIV_LO,
            MODE_DIV_HI: evt_o = hit;
            default:     evt_o = 1'b0;
        endcase
    end

    always_comb begin
        cnt_d = cnt_q;
        if (!is_capture(mode_i)) begin
            cnt_d = '0;
        end else if (is_scaled(mode_i) && rise_i) begin
            cnt_d = hit ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/tcap_fsm.sv
`timescale 1ns/1ps
module tcap_fsm
    import tcap_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [3:0] mode_i,
    input  logic       evt_i,
    output cap_state_e state_o,
    output logic       grab_o
);
    cap_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_OFF;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  state_d = is_capture(mode_i) ? (evt_i ? ST_GRAB : ST_ARM) : ST_OFF;
            ST_ARM:  state_d = !is_capture(mode_i) ? ST_OFF : (evt_i ? ST_GRAB : ST_ARM);
            ST_GRAB: state_d = !is_capture(mode_i) ? ST_OFF : (evt_i ? ST_GRAB : ST_ARM);
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        grab_o = (state_q == ST_GRAB);
    end

    assign state_o = state_q;
endmodule

// File: rtl/tcap_unit.sv
`timescale 1ns/1ps
module tcap_unit
    import tcap_pkg::*;
#(
    parameter int TW          = 16,
    parameter int SYNC_STAGES = 2,
    parameter int PS_LO       = 4,
    parameter int PS_HI       = 16,
    localparam int CW         = $clog2(PS_HI)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [3:0]    mode_i,
    input  logic          tsel_i,
    input  logic          pin_i,
    input  logic [TW-1:0] tmr_a_i,
    input  logic [TW-1:0] tmr_b_i,
    input  logic          flag_clr_i,
    output logic [TW-1:0] cap_o,
    output logic          flag_o
);
    logic          rise, fall, evt, grab;
    logic [CW-1:0] ps_cnt;
    cap_state_e    state_q;
    logic [TW-1:0] cap_q;
    logic          flag_q;

    tcap_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i), .rst_ni (rst_ni), .pin_i (pin_i),
        .rise_o(rise),  .fall_o (fall)
    );

    tcap_prescale #(.PS_LO(PS_LO), .PS_HI(PS_HI)) u_ps (
        .clk_i (clk_i), .rst_ni (rst_ni), .mode_i (mode_i),
        .rise_i(rise),  .fall_i (fall),   .evt_o  (evt), .cnt_o (ps_cnt)
    );

    tcap_fsm u_fsm (
        .clk_i (clk_i), .rst_ni (rst_ni), .mode_i (mode_i),
        .evt_i (evt),   .state_o(state_q), .grab_o (grab)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cap_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (grab) cap_q <= tsel_i ? tmr_b_i : tmr_a_i;
            // set has priority over the software clear
            if (grab)            flag_q <= 1'b1;
            else if (flag_clr_i) flag_q <= 1'b0;
        end
    end

    assign cap_o  = cap_q;
    assign flag_o = flag_q;
endmodule

// File: rtl/tcap_unit_chk.sv
`timescale 1ns/1ps
module tcap_unit_chk
    import tcap_pkg::*;
#(
    parameter int TW = 16,
    parameter int CW = 4
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic [3:0]    mode_i,
    input logic          flag_clr_i,
    input logic          flag_o,
    input logic [TW-1:0] cap_o,
    input cap_state_e    state_q,
    input logic          evt,
    input logic [CW-1:0] ps_cnt
);
    assert_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_o && !flag_clr_i) |=> flag_o);

    assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_GRAB) |=> flag_o);

    assert_cap_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != ST_GRAB) |=> $stable(cap_o));

    assert_grab_needs_event_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_GRAB) |-> $past(evt));

    assert_off_no_grab_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!is_capture(mode_i)) |=> (state_q != ST_GRAB));

    assert_ps_cleared_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!is_capture(mode_i)) |=> (ps_cnt == '0));
endmodule

bind tcap_unit tcap_unit_chk #(.TW(TW), .CW(CW)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_i),
    .flag_clr_i(flag_clr_i),
    .flag_o    (flag_o),
    .cap_o     (cap_o),
    .state_q   (state_q),
    .evt       (evt),
    .ps_cnt    (ps_cnt)
);

// File: tb/tcap_unit_bench.sv
`timescale 1ns/1ps
module tcap_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  mode = 4'b0000;
    logic        tsel = 1'b0;
    logic        pin = 1'b0;
    logic [15:0] tmr_a = 16'h1234;
    logic [15:0] tmr_b = 16'hBEEF;
    logic        flag_clr = 1'b0;
    logic [15:0] cap;
    logic        flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    tcap_unit u_tcap_unit (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .tsel_i(tsel),
        .pin_i(pin), .tmr_a_i(tmr_a), .tmr_b_i(tmr_b),
        .flag_clr_i(flag_clr), .cap_o(cap), .flag_o(flag)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        pin = 1'b1; cyc(3);
        pin = 1'b0; cyc(3);
    endtask

    task automatic clr();
        flag_clr = 1'b1; cyc(1);
        flag_clr = 1'b0; cyc(1);
    endtask

    task automatic push(input logic [15:0] v, input string req);
        exp_q.push_back(v);
        tag_q.push_back(req);
    endtask

    task automatic drain(input string req);
        cyc(4);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    task automatic go_mode(input logic [3:0] m);
        mode = 4'b0000; cyc(2);
        mode = m;       cyc(2);
    endtask

    // monitor: each new flag rise pops one expected capture
    logic flag_d = 1'b0;
    always @(negedge clk) begin
        if (rst_n && flag && !flag_d) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "unexpected capture", cap, 0);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(cap == e, t, cap, e);
            end
        end
        flag_d = flag;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk(cap == 16'h0, "R1 cap", cap, 0);
        chk(flag == 1'b0, "R1 flag", flag, 0);

        // R2 and R11: rising mode, latency of four clock edges
        go_mode(4'b0101);
        push(16'h1234, "R2");
        pin = 1'b1; cyc(3);
        chk(flag == 1'b0, "R11 early", flag, 0);
        cyc(1);
        chk(flag == 1'b1, "R11 at edge 4", flag, 1);
        cyc(2); clr();
        pin = 1'b0; cyc(6);
        chk(flag == 1'b0, "R2 fall ignored", flag, 0);

        // R3: falling mode
        go_mode(4'b0100);
        pin = 1'b1; cyc(6);
        chk(flag == 1'b0, "R3 rise ignored", flag, 0);
        push(16'h1234, "R3");
        pin = 1'b0; cyc(2);
        drain("R3");
        clr();

        // R6: timer B select
        tsel = 1'b1;
        go_mode(4'b0101);
        push(16'hBEEF, "R6");
        pulse(); drain("R6");
        clr(); tsel = 1'b0;

        // R4: divide by 4
        go_mode(4'b0110);
        repeat (3) pulse();
        chk(flag == 1'b0, "R4 before 4th", flag, 0);
        push(16'h1234, "R4");
        pulse(); drain("R4");
        clr();

        // R5: divide by 16
        go_mode(4'b0111);
        repeat (15) pulse();
        chk(flag == 1'b0, "R5 before 16th", flag, 0);
        push(16'h1234, "R5");
        pulse(); drain("R5");

        // R7: sticky flag, then set wins over clear
        cyc(10);
        chk(flag == 1'b1, "R7 sticky", flag, 1);
        clr();
        chk(flag == 1'b0, "R7 cleared", flag, 0);
        go_mode(4'b0101);
        push(16'h1234, "R7 set wins");
        pin = 1'b1; flag_clr = 1'b1; cyc(4);
        flag_clr = 1'b0; cyc(1);
        chk(flag == 1'b1, "R7 set over clear", flag, 1);
        pin = 1'b0; cyc(3);
        clr();

        // R8: overwrite while the flag is still set
        push(16'h1234, "R8 first");
        pulse(); drain("R8");
        tmr_a = 16'h5678;
        pulse(); cyc(2);
        chk(cap == 16'h5678, "R8 overwrite", cap, 16'h5678);
        chk(flag == 1'b1, "R8 flag kept", flag, 1);
        cyc(5);
        chk(cap == 16'h5678, "R8 hold", cap, 16'h5678);
        clr();

        // R9: off and non-capture codes
        go_mode(4'b0000);
        pulse(); cyc(2);
        chk(flag == 1'b0, "R9 off", flag, 0);
        go_mode(4'b1010);
        pulse(); cyc(2);
        chk(flag == 1'b0, "R9 other code", flag, 0);
        go_mode(4'b0111);
        repeat (5) pulse();
        mode = 4'b1010; cyc(2);
        mode = 4'b0110; cyc(2);
        repeat (3) pulse();
        chk(flag == 1'b0, "R9 counter cleared", flag, 0);
        push(16'h5678, "R9 fresh count");
        pulse(); drain("R9");
        clr();

        // R10: direct switch keeps the count, early capture
        go_mode(4'b0111);
        repeat (6) pulse();
        chk(flag == 1'b0, "R10 before switch", flag, 0);
        mode = 4'b0110; cyc(2);
        push(16'h5678, "R10 early");
        pulse(); drain("R10");
        clr();

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule